// File: doc/BRIEF.md
# Pin-Change and External Interrupt Front End

This block sits between a microcontroller's general-purpose input pins and its CPU. It watches two pin groups and one dedicated external interrupt pin:

- Group 0 has eight pins by default.
- Group 1 has four pins by default.

All pins pass through a two-flop synchronizer. A pin change is found by comparing the synchronized level with its value one cycle earlier. Each group has a per-pin mask. A change on any unmasked pin of a group latches that group's single flag.

The external pin has a 2-bit sense input that picks one of four behaviours: low level, any change, falling edge or rising edge. In the low-level mode the request follows the pin directly and the pin's flag is held at zero.

Software reaches the flag, enable and mask registers through a byte-wide register port. Writes take effect on the clock edge; reads are combinational.

- A flag clears when software writes a one to its bit, or when the CPU acknowledges vectoring to that source.
- If a new event arrives in the same cycle as a clear, the event wins.
- Each request output is the source's flag, gated by its enable bit and by a global interrupt enable input.

This block has no streaming data path, so every pin is a plain control or status signal with no back-pressure.

Top module: `pcx_irq_ctrl`

## Requirements
- R1: A level change on a group-0 pin whose bit is set in the group-0 mask register (address 2) sets the group-0 flag, bit 4 of the flag register (address 0). The flag is readable after the third rising clock edge following the pin change.
- R2: A level change on a group-1 pin whose bit is set in the group-1 mask register (address 3, bits 3..0 for the four pins) sets the group-1 flag, bit 5 of the flag register, with the same latency as R1.
- R3: A change on a pin whose mask bit is clear leaves its group flag at zero.
- R4: Writing a one to a flag bit at address 0 clears that flag. Writing a zero leaves the flag unchanged.
- R5: A pulse on `ack_i` clears the matching flag. Bit 0 of `ack_i` is the external source, bit 1 is group 0 and bit 2 is group 1.
- R6: The external flag (bit 6 of the flag register) is set according to `ext_sense_i`: 1 sets it on any change, 2 on a falling edge only, 3 on a rising edge only.
- R7: With `ext_sense_i` = 0 (low level), the external flag always reads zero. `irq_o[0]` is high whenever the synchronized external pin is low and the external enable and `gie_i` are both set.
- R8: Outside level mode, `irq_o[i]` is high only when the source's flag, its enable bit and `gie_i` are all set. The enable bits sit in the enable register (address 1): bit 4 for group 0, bit 5 for group 1 and bit 6 for the external pin.
- R9: All register bits reset to zero. The following bits read zero:
  - bits 7 and 3..0 of the flag register;
  - bits 7 and 3..0 of the enable register;
  - bits 7..4 of the group-1 mask register.
- R10: When a new event and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_g0_i | input | G0_W | Group-0 pins (asynchronous) |
| pin_g1_i | input | G1_W | Group-1 pins (asynchronous) |
| pin_ext_i | input | 1 | External interrupt pin (asynchronous) |
| ext_sense_i | input | 2 | External pin sense: 0 low, 1 any change, 2 falling, 3 rising |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 3 | Vector-entry acknowledge per source (0 external, 1 group 0, 2 group 1) |
| reg_addr_i | input | 2 | Register select: 0 flags, 1 enables, 2 group-0 mask, 3 group-1 mask |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from `reg_addr_i` |
| irq_o | output | 3 | Interrupt requests, same bit order as `ack_i` |

## Verification
Every pin of both groups is toggled once with a mask that selects only that pin, and once with a mask that selects every other pin. This separates correct per-pin masking from a group OR that ignores the mask, and from a mask applied to the wrong bit.

The external pin is driven through both edge directions in each of the three edge modes. This tells edge polarity apart from any-change detection.

All eight combinations of flag, enable and global enable are tried on one source to show that the request is an AND of the three.

Clears are timed to coincide with a fresh event, and are also applied alone. This distinguishes set-over-clear priority from a plain clear path.

// File: rtl/pcx_pkg.sv
`timescale 1ns/1ps
package pcx_pkg;
  localparam int REG_W       = 8;
  localparam int FLAG_G0_BIT = 4;
  localparam int FLAG_G1_BIT = 5;
  localparam int FLAG_EX_BIT = 6;

  localparam int SRC_EXT = 0;
  localparam int SRC_G0  = 1;
  localparam int SRC_G1  = 2;
  localparam int SRC_N   = 3;

  typedef enum logic [1:0] {
    ADR_FLAG = 2'd0,
    ADR_ENA  = 2'd1,
    ADR_MSK0 = 2'd2,
    ADR_MSK1 = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'd0,
    SNS_ANY  = 2'd1,
    SNS_FALL = 2'd2,
    SNS_RISE = 2'd3
  } sense_e;
endpackage

// File: rtl/pcx_sync.sv
`timescale 1ns/1ps
module pcx_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= async_i[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign sync_o[i] = sync_q;
    assign prev_o[i] = prev_q;
  end
endmodule

// File: rtl/pcx_group_det.sv
`timescale 1ns/1ps
module pcx_group_det #(
  parameter int W = 8
) (
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] mask_i,
  output logic         evt_o
);
  logic [W-1:0] moved;
  assign moved = (sync_i ^ prev_i) & mask_i;
  assign evt_o = |moved;
endmodule

// File: rtl/pcx_ext_det.sv
`timescale 1ns/1ps
module pcx_ext_det
  import pcx_pkg::*;
(
  input  logic       sync_i,
  input  logic       prev_i,
  input  logic [1:0] sense_i,
  output logic       evt_o,
  output logic       level_mode_o,
  output logic       level_act_o
);
  logic rise, fall;
  assign rise = sync_i & ~prev_i;
  assign fall = ~sync_i & prev_i;

  always_comb begin
    evt_o = 1'b0;
    unique case (sense_e'(sense_i))
      SNS_LOW:  evt_o = 1'b0;
      SNS_ANY:  evt_o = rise | fall;
      SNS_FALL: evt_o = fall;
      SNS_RISE: evt_o = rise;
      default:  evt_o = 1'b0;
    endcase
  end

  assign level_mode_o = (sense_e'(sense_i) == SNS_LOW);
  assign level_act_o  = level_mode_o & ~sync_i;
endmodule

// File: rtl/pcx_irq_ctrl.sv
`timescale 1ns/1ps
module pcx_irq_ctrl
  import pcx_pkg::*;
#(
  parameter int G0_W = 8,
  parameter int G1_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [G0_W-1:0]      pin_g0_i,
  input  logic [G1_W-1:0]      pin_g1_i,
  input  logic                 pin_ext_i,
  input  logic [1:0]           ext_sense_i,
  input  logic                 gie_i,
  input  logic [SRC_N-1:0]     ack_i,
  input  logic [1:0]           reg_addr_i,
  input  logic                 reg_wr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  output logic [SRC_N-1:0]     irq_o
);
  localparam int PIN_N = G0_W + G1_W + 1;

  logic [PIN_N-1:0] pins_async, pins_sync, pins_prev;
  assign pins_async = {pin_ext_i, pin_g1_i, pin_g0_i};

  pcx_sync #(.W(PIN_N)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pins_async),
    .sync_o  (pins_sync),
    .prev_o  (pins_prev)
  );

  logic [G0_W-1:0] msk0_q;
  logic [G1_W-1:0] msk1_q;
  logic            ena_g0_q, ena_g1_q, ena_ex_q;
  logic            flag_g0, flag_g1, flag_ex;
  logic            evt_g0, evt_g1, evt_ex, lvl_mode, lvl_act;

  pcx_group_det #(.W(G0_W)) u_det_g0 (
    .sync_i (pins_sync[G0_W-1:0]),
    .prev_i (pins_prev[G0_W-1:0]),
    .mask_i (msk0_q),
    .evt_o  (evt_g0)
  );

  pcx_group_det #(.W(G1_W)) u_det_g1 (
    .sync_i (pins_sync[G0_W+G1_W-1:G0_W]),
    .prev_i (pins_prev[G0_W+G1_W-1:G0_W]),
    .mask_i (msk1_q),
    .evt_o  (evt_g1)
  );

  pcx_ext_det u_det_ex (
    .sync_i       (pins_sync[PIN_N-1]),
    .prev_i       (pins_prev[PIN_N-1]),
    .sense_i      (ext_sense_i),
    .evt_o        (evt_ex),
    .level_mode_o (lvl_mode),
    .level_act_o  (lvl_act)
  );

  logic wr_flag, wr_ena, wr_m0, wr_m1;
  assign wr_flag = reg_wr_i && (reg_addr_e'(reg_addr_i) == ADR_FLAG);
  assign wr_ena  = reg_wr_i && (reg_addr_e'(reg_addr_i) == ADR_ENA);
  assign wr_m0   = reg_wr_i && (reg_addr_e'(reg_addr_i) == ADR_MSK0);
  assign wr_m1   = reg_wr_i && (reg_addr_e'(reg_addr_i) == ADR_MSK1);

  logic clr_g0, clr_g1, clr_ex;
  assign clr_g0 = (wr_flag && reg_wdata_i[FLAG_G0_BIT]) || ack_i[SRC_G0];
  assign clr_g1 = (wr_flag && reg_wdata_i[FLAG_G1_BIT]) || ack_i[SRC_G1];
  assign clr_ex = (wr_flag && reg_wdata_i[FLAG_EX_BIT]) || ack_i[SRC_EXT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk0_q   <= '0;
      msk1_q   <= '0;
      ena_g0_q <= 1'b0;
      ena_g1_q <= 1'b0;
      ena_ex_q <= 1'b0;
      flag_g0  <= 1'b0;
      flag_g1  <= 1'b0;
      flag_ex  <= 1'b0;
    end else begin
      if (wr_m0) msk0_q <= reg_wdata_i[G0_W-1:0];
      if (wr_m1) msk1_q <= reg_wdata_i[G1_W-1:0];
      if (wr_ena) begin
        ena_g0_q <= reg_wdata_i[FLAG_G0_BIT];
        ena_g1_q <= reg_wdata_i[FLAG_G1_BIT];
        ena_ex_q <= reg_wdata_i[FLAG_EX_BIT];
      end
      flag_g0 <= evt_g0 | (flag_g0 & ~clr_g0);
      flag_g1 <= evt_g1 | (flag_g1 & ~clr_g1);
      flag_ex <= lvl_mode ? 1'b0 : (evt_ex | (flag_ex & ~clr_ex));
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_e'(reg_addr_i))
      ADR_FLAG: begin
        reg_rdata_o[FLAG_G0_BIT] = flag_g0;
        reg_rdata_o[FLAG_G1_BIT] = flag_g1;
        reg_rdata_o[FLAG_EX_BIT] = flag_ex;
      end
      ADR_ENA: begin
        reg_rdata_o[FLAG_G0_BIT] = ena_g0_q;
        reg_rdata_o[FLAG_G1_BIT] = ena_g1_q;
        reg_rdata_o[FLAG_EX_BIT] = ena_ex_q;
      end
      ADR_MSK0: reg_rdata_o[G0_W-1:0] = msk0_q;
      ADR_MSK1: reg_rdata_o[G1_W-1:0] = msk1_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o[SRC_G0]  = gie_i & ena_g0_q & flag_g0;
  assign irq_o[SRC_G1]  = gie_i & ena_g1_q & flag_g1;
  assign irq_o[SRC_EXT] = gie_i & ena_ex_q & (lvl_mode ? lvl_act : flag_ex);
endmodule

// File: rtl/pcx_irq_chk.sv
`timescale 1ns/1ps
module pcx_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_g0,
  input logic       flag_g0,
  input logic [1:0] ext_sense_i,
  input logic [1:0] reg_addr_i,
  input logic       reg_wr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       gie_i,
  input logic [2:0] ack_i,
  input logic [2:0] irq_o
);
  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 2'd0 && reg_wdata_i[4] && !evt_g0) |=> !flag_g0);

  p_zero_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 2'd0 && !reg_wdata_i[4] && !ack_i[1] && flag_g0) |=> flag_g0);

  p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i[1] && !evt_g0) |=> !flag_g0);

  p_level_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sense_i == 2'd0 && reg_addr_i == 2'd0) |-> !reg_rdata_o[6]);

  p_gie_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> (irq_o == 3'b000));

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == 2'd0) |-> (!reg_rdata_o[7] && reg_rdata_o[3:0] == 4'd0));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_g0 |=> flag_g0);
endmodule

bind pcx_irq_ctrl pcx_irq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_g0      (evt_g0),
  .flag_g0     (flag_g0),
  .ext_sense_i (ext_sense_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .gie_i       (gie_i),
  .ack_i       (ack_i),
  .irq_o       (irq_o)
);

// File: tb/pcx_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pcx_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_g0 = '0;
  logic [3:0] pin_g1 = '0;
  logic       pin_ext = 1'b0;
  logic [1:0] sense = 2'd1;
  logic       gie = 1'b0;
  logic [2:0] ack = '0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcx_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pin_g0_i(pin_g0), .pin_g1_i(pin_g1),
    .pin_ext_i(pin_ext), .ext_sense_i(sense), .gie_i(gie), .ack_i(ack),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset values
    for (int a = 0; a < 4; a++) begin
      rreg(2'(a), d);
      chk(d, 8'h00, "R9 reset register");
    end
    chk({5'd0, irq}, 8'h00, "R9 reset irq");

    // R9: reserved bits
    wreg(2'd3, 8'hFF); rreg(2'd3, d); chk(d, 8'h0F, "R9 group-1 mask upper bits");
    wreg(2'd1, 8'hFF); rreg(2'd1, d); chk(d, 8'h70, "R9 enable reserved bits");
    wreg(2'd1, 8'h00);
    wreg(2'd3, 8'h00);

    // R1 / R3: group-0 sweep
    for (int p = 0; p < 8; p++) begin
      for (int sel = 0; sel < 2; sel++) begin
        wreg(2'd2, sel ? (8'h01 << p) : ~(8'h01 << p));
        @(negedge clk); pin_g0[p] = ~pin_g0[p];
        settle();
        rreg(2'd0, d);
        chk(d, sel ? 8'h10 : 8'h00, sel ? "R1 group-0 unmasked change" : "R3 group-0 masked change");
        wreg(2'd0, 8'hFF);
        rreg(2'd0, d); chk(d, 8'h00, "R4 write-one clears group-0");
      end
    end
    wreg(2'd2, 8'h00);

    // R2 / R3: group-1 sweep
    for (int p = 0; p < 4; p++) begin
      for (int sel = 0; sel < 2; sel++) begin
        wreg(2'd3, sel ? (8'h01 << p) : (~(8'h01 << p) & 8'h0F));
        @(negedge clk); pin_g1[p] = ~pin_g1[p];
        settle();
        rreg(2'd0, d);
        chk(d, sel ? 8'h20 : 8'h00, sel ? "R2 group-1 unmasked change" : "R3 group-1 masked change");
        wreg(2'd0, 8'h20);
        rreg(2'd0, d); chk(d, 8'h00, "R4 write-one clears group-1");
      end
    end

    // R6: external edge modes
    for (int m = 1; m < 4; m++) begin
      for (int up = 0; up < 2; up++) begin
        sense = 2'(m);
        @(negedge clk); pin_ext = ~up[0];
        settle();
        wreg(2'd0, 8'h40);
        @(negedge clk); pin_ext = up[0];
        settle();
        rreg(2'd0, d);
        chk(d, ((m == 1) || (m == 2 && up == 0) || (m == 3 && up == 1)) ? 8'h40 : 8'h00,
            "R6 external sense mode edge");
        wreg(2'd0, 8'h40);
      end
    end

    // R7: level mode
    wreg(2'd1, 8'h40);
    gie = 1'b1;
    @(negedge clk); pin_ext = 1'b0; sense = 2'd0;
    settle();
    rreg(2'd0, d); chk(d, 8'h00, "R7 level mode flag reads zero");
    chk({7'd0, irq[0]}, 8'h01, "R7 level low raises request");
    @(negedge clk); pin_ext = 1'b1;
    settle();
    chk({7'd0, irq[0]}, 8'h00, "R7 level high drops request");
    @(negedge clk); pin_ext = 1'b0;
    settle();
    chk({7'd0, irq[0]}, 8'h01, "R7 level low again");
    @(negedge clk); pin_ext = 1'b1; sense = 2'd1;
    settle();
    wreg(2'd0, 8'h40);
    gie = 1'b0;

    // R8: gating sweep on group 0
    wreg(2'd2, 8'h01);
    for (int g = 0; g < 2; g++)
      for (int e = 0; e < 2; e++)
        for (int f = 0; f < 2; f++) begin
          wreg(2'd1, e ? 8'h10 : 8'h00);
          if (f != 0) begin
            @(negedge clk); pin_g0[0] = ~pin_g0[0];
            settle();
          end
          @(negedge clk); gie = g[0];
          #1 chk({7'd0, irq[1]}, {7'd0, g[0] & e[0] & f[0]}, "R8 request gating");
          gie = 1'b0;
          wreg(2'd0, 8'h70);
        end

    // R5: acknowledge clears
    @(negedge clk); pin_g0[0] = ~pin_g0[0];
    settle();
    @(negedge clk); ack = 3'b010;
    @(negedge clk); ack = 3'b000;
    rreg(2'd0, d); chk(d, 8'h00, "R5 ack clears group-0");
    wreg(2'd3, 8'h01);
    @(negedge clk); pin_g1[0] = ~pin_g1[0];
    settle();
    @(negedge clk); ack = 3'b001;
    @(negedge clk); ack = 3'b000;
    rreg(2'd0, d); chk(d, 8'h20, "R5 ack of other source keeps group-1");
    @(negedge clk); ack = 3'b100;
    @(negedge clk); ack = 3'b000;
    rreg(2'd0, d); chk(d, 8'h00, "R5 ack clears group-1");

    // R10: set beats clear in same cycle
    @(negedge clk); pin_g0[0] = ~pin_g0[0];
    settle();
    @(negedge clk); pin_g0[0] = ~pin_g0[0];
    repeat (2) @(posedge clk);
    @(negedge clk); addr = 2'd0; wdata = 8'h10; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    rreg(2'd0, d); chk(d, 8'h10, "R10 event wins over write clear");
    @(negedge clk); pin_g0[0] = ~pin_g0[0];
    repeat (2) @(posedge clk);
    @(negedge clk); ack = 3'b010;
    @(negedge clk); ack = 3'b000;
    rreg(2'd0, d); chk(d, 8'h10, "R10 event wins over ack");
    wreg(2'd0, 8'h00);
    rreg(2'd0, d); chk(d, 8'h10, "R4 zero write keeps flag");
    wreg(2'd0, 8'h10);
    rreg(2'd0, d); chk(d, 8'h00, "R4 one write clears flag");

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule